// File: doc/BRIEF.md
# Preloaded Computation Result Table

This block holds a small set of arithmetic computations whose results are known before a program starts. Each stored entry pairs an opcode and two operand values with the value they produce. Software fills the table through a write port while a load-phase signal is high. Once that signal drops, the contents are frozen. Only a flush, for example on a context switch, can still change them, and it invalidates every entry at once.

While the program runs, two pipeline stages query the table in the same cycle. Each stage has its own read port and receives a combinational hit flag and result. A dispatch-stage hit lets the instruction leave the pipeline and wait only for in-order commit. An issue-stage hit still reports the result, but the bypass is taken only when no functional unit is free; otherwise the instruction executes as usual. Every entry is compared against the query in parallel, and when several entries match, the lowest index supplies the result.

Top module: `precomp_table`

## Requirements
- R1: After reset (active-low `rst_n`) every entry is invalid, so both ports report a miss with a result of zero.
- R2: With `load_mode` high and `ld_we` high, the entry at `ld_idx` takes opcode, operands and result at the clock edge and becomes valid. A write with `load_mode` low has no effect.
- R3: An opcode is arithmetic class when its most significant bit is 0. A write that carries an opcode with that bit set is dropped, and a lookup that carries such an opcode misses.
- R4: A lookup hits only when its valid input is high and a valid entry holds an equal opcode, an equal first operand and an equal second operand (operand order matters). The result is that entry's stored result. On a miss the result is zero.
- R5: When several valid entries match, the entry with the lowest index supplies the result.
- R6: While `load_mode` is high, both ports report a miss.
- R7: The dispatch bypass output equals the dispatch hit flag.
- R8: The issue port reports its hit flag and result regardless of `iq_fu_free`. Its bypass output is high only on a hit while `iq_fu_free` is low.
- R9: A `flush` pulse invalidates every entry by the next cycle and takes priority over a write in the same cycle.
- R10: With `load_mode` low and no flush, no entry changes.
- R11: The two ports resolve independent queries in the same cycle. This includes a query that matches the last index, DEPTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Invalidate all entries |
| load_mode | input | 1 | Load phase enable |
| ld_we | input | 1 | Entry write strobe |
| ld_idx | input | IDX_W | Entry index to write |
| ld_opc | input | OPC_W | Opcode to store |
| ld_a | input | DATA_W | First operand to store |
| ld_b | input | DATA_W | Second operand to store |
| ld_res | input | DATA_W | Result to store |
| dq_vld | input | 1 | Dispatch lookup valid |
| dq_opc | input | OPC_W | Dispatch opcode |
| dq_a | input | DATA_W | Dispatch first operand |
| dq_b | input | DATA_W | Dispatch second operand |
| dq_hit | output | 1 | Dispatch hit |
| dq_res | output | DATA_W | Dispatch result |
| dq_bypass | output | 1 | Dispatch removes instruction |
| iq_vld | input | 1 | Issue lookup valid |
| iq_opc | input | OPC_W | Issue opcode |
| iq_a | input | DATA_W | Issue first operand |
| iq_b | input | DATA_W | Issue second operand |
| iq_fu_free | input | 1 | A functional unit is free |
| iq_hit | output | 1 | Issue hit |
| iq_res | output | DATA_W | Issue result |
| iq_bypass | output | 1 | Issue takes stored result |

## Verification
Several properties are checked on every cycle. Contents stay frozen outside the load phase, a flush empties the table by the next edge, and an accepted write lands at its index. A hit never appears during the load phase or for a non-arithmetic opcode. A miss always returns zero, and the issue bypass never fires while a unit is free. Other behaviours appear only in the bench's scenarios. These are exact operand-order matching, lowest-index priority among duplicates, writes dropped for lack of load phase or class, flush winning over a simultaneous write, and reset clearing a filled table.

// File: rtl/ppt_pkg.sv
package ppt_pkg;
    parameter int OPC_W  = 6;
    parameter int DATA_W = 32;

    typedef struct packed {
        logic              vld;
        logic [OPC_W-1:0]  opc;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic [DATA_W-1:0] res;
    } ppt_entry_t;

    function automatic logic is_arith(input logic [OPC_W-1:0] opc);
        return !opc[OPC_W-1];
    endfunction
endpackage

// File: rtl/ppt_store.sv
module ppt_store
    import ppt_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush_i,
    input  logic                    load_mode_i,
    input  logic                    we_i,
    input  logic [IDX_W-1:0]        idx_i,
    input  logic [OPC_W-1:0]        opc_i,
    input  logic [DATA_W-1:0]       a_i,
    input  logic [DATA_W-1:0]       b_i,
    input  logic [DATA_W-1:0]       res_i,
    output ppt_entry_t [DEPTH-1:0]  ent_o
);
    typedef struct packed {
        ppt_entry_t [DEPTH-1:0] ent;
    } st_t;

    st_t st_d, st_q;
    logic wr_ok;

    assign wr_ok = load_mode_i && we_i && is_arith(opc_i)
                   && (32'(idx_i) < DEPTH);

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            for (int i = 0; i < DEPTH; i++) st_d.ent[i].vld = 1'b0;
        end else if (wr_ok) begin
            st_d.ent[idx_i].vld = 1'b1;
            st_d.ent[idx_i].opc = opc_i;
            st_d.ent[idx_i].a   = a_i;
            st_d.ent[idx_i].b   = b_i;
            st_d.ent[idx_i].res = res_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ent_o = st_q.ent;

    logic [DEPTH-1:0] vld_vec;
    always_comb for (int i = 0; i < DEPTH; i++) vld_vec[i] = st_q.ent[i].vld;

    // R10
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_mode_i && !flush_i) |=> $stable(st_q));
    // R9
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (vld_vec == '0));
    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_mode_i && we_i && !flush_i && is_arith(opc_i)) |=>
        (st_q.ent[$past(idx_i)].res == $past(res_i) && st_q.ent[$past(idx_i)].vld));
endmodule

// File: rtl/ppt_match.sv
module ppt_match
    import ppt_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  ppt_entry_t [DEPTH-1:0]  ent_i,
    input  logic                    lock_i,
    input  logic                    vld_i,
    input  logic [OPC_W-1:0]        opc_i,
    input  logic [DATA_W-1:0]       a_i,
    input  logic [DATA_W-1:0]       b_i,
    output logic                    hit_o,
    output logic [DATA_W-1:0]       res_o
);
    logic [DEPTH-1:0]  eq;
    logic              found;
    logic [DATA_W-1:0] pick;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign eq[g] = ent_i[g].vld && (ent_i[g].opc == opc_i)
                       && (ent_i[g].a == a_i) && (ent_i[g].b == b_i);
    end

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (eq[i] && !found) begin
                found = 1'b1;
                pick  = ent_i[i].res;
            end
        end
    end

    always_comb begin
        hit_o = found && vld_i && !lock_i && is_arith(opc_i);
        res_o = hit_o ? pick : '0;
    end

    // R6
    no_hit_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> !lock_i);
    // R3
    arith_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> !opc_i[OPC_W-1]);
    // R4
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> (res_o == '0));
endmodule

// File: rtl/precomp_table.sv
module precomp_table
    import ppt_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      load_mode,
    input  logic                      ld_we,
    input  logic [IDX_W-1:0]          ld_idx,
    input  logic [ppt_pkg::OPC_W-1:0] ld_opc,
    input  logic [ppt_pkg::DATA_W-1:0] ld_a,
    input  logic [ppt_pkg::DATA_W-1:0] ld_b,
    input  logic [ppt_pkg::DATA_W-1:0] ld_res,
    input  logic                      dq_vld,
    input  logic [ppt_pkg::OPC_W-1:0] dq_opc,
    input  logic [ppt_pkg::DATA_W-1:0] dq_a,
    input  logic [ppt_pkg::DATA_W-1:0] dq_b,
    output logic                      dq_hit,
    output logic [ppt_pkg::DATA_W-1:0] dq_res,
    output logic                      dq_bypass,
    input  logic                      iq_vld,
    input  logic [ppt_pkg::OPC_W-1:0] iq_opc,
    input  logic [ppt_pkg::DATA_W-1:0] iq_a,
    input  logic [ppt_pkg::DATA_W-1:0] iq_b,
    input  logic                      iq_fu_free,
    output logic                      iq_hit,
    output logic [ppt_pkg::DATA_W-1:0] iq_res,
    output logic                      iq_bypass
);
    ppt_entry_t [DEPTH-1:0] ent;

    ppt_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .flush_i(flush), .load_mode_i(load_mode),
        .we_i(ld_we), .idx_i(ld_idx), .opc_i(ld_opc), .a_i(ld_a),
        .b_i(ld_b), .res_i(ld_res), .ent_o(ent)
    );

    ppt_match #(.DEPTH(DEPTH)) u_disp (
        .clk(clk), .rst_n(rst_n), .ent_i(ent), .lock_i(load_mode),
        .vld_i(dq_vld), .opc_i(dq_opc), .a_i(dq_a), .b_i(dq_b),
        .hit_o(dq_hit), .res_o(dq_res)
    );

    ppt_match #(.DEPTH(DEPTH)) u_issue (
        .clk(clk), .rst_n(rst_n), .ent_i(ent), .lock_i(load_mode),
        .vld_i(iq_vld), .opc_i(iq_opc), .a_i(iq_a), .b_i(iq_b),
        .hit_o(iq_hit), .res_o(iq_res)
    );

    assign dq_bypass = dq_hit;
    assign iq_bypass = iq_hit && !iq_fu_free;

    // R8
    issue_bypass_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iq_bypass |-> (!iq_fu_free && iq_hit));
    // R6
    no_bypass_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_mode |-> (!dq_bypass && !iq_bypass));
endmodule

// File: tb/precomp_table_test.sv
`timescale 1ns/100ps
module precomp_table_test;
    localparam int DEPTH = 16;
    localparam int IW = $clog2(DEPTH);
    localparam int NV = 9;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, flush, load_mode, ld_we;
    logic [IW-1:0] ld_idx;
    logic [5:0] ld_opc, dq_opc, iq_opc;
    logic [31:0] ld_a, ld_b, ld_res, dq_a, dq_b, iq_a, iq_b;
    logic dq_vld, iq_vld, iq_fu_free;
    logic dq_hit, dq_bypass, iq_hit, iq_bypass;
    logic [31:0] dq_res, iq_res;

    precomp_table #(.DEPTH(DEPTH)) uut (.*);

    int nchk = 0, nfail = 0;
    bit done = 0;

    // fields: opc(6) a(32) b(32) fu_free(1) exp_hit(1) exp_res(32)
    localparam logic [103:0] VEC [NV] = '{
        {6'd1,  32'd5, 32'd7, 1'b1, 1'b1, 32'd12},
        {6'd1,  32'd5, 32'd7, 1'b0, 1'b1, 32'd12},
        {6'd2,  32'd3, 32'd4, 1'b0, 1'b1, 32'd12},
        {6'd2,  32'd4, 32'd3, 1'b0, 1'b0, 32'd0},
        {6'd1,  32'd5, 32'd8, 1'b0, 1'b0, 32'd0},
        {6'd3,  32'd0, 32'd0, 1'b0, 1'b1, 32'hDEAD},
        {6'h20, 32'd9, 32'd9, 1'b0, 1'b0, 32'd0},
        {6'd4,  32'd1, 32'd1, 1'b0, 1'b0, 32'd0},
        {6'd5,  32'd5, 32'd7, 1'b1, 1'b0, 32'd0}
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(int idx, logic [5:0] opc, logic [31:0] a, logic [31:0] b,
                      logic [31:0] res);
        @(negedge clk);
        ld_we = 1; ld_idx = IW'(idx); ld_opc = opc; ld_a = a; ld_b = b; ld_res = res;
        @(negedge clk);
        ld_we = 0;
    endtask

    task automatic look(logic [5:0] opc, logic [31:0] a, logic [31:0] b, logic fu);
        @(negedge clk);
        dq_vld = 1; iq_vld = 1;
        dq_opc = opc; dq_a = a; dq_b = b;
        iq_opc = opc; iq_a = a; iq_b = b; iq_fu_free = fu;
        #1;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            nfail++; nchk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; flush = 0; load_mode = 0; ld_we = 0; ld_idx = '0;
        ld_opc = '0; ld_a = '0; ld_b = '0; ld_res = '0;
        dq_vld = 0; iq_vld = 0; dq_opc = '0; dq_a = '0; dq_b = '0;
        iq_opc = '0; iq_a = '0; iq_b = '0; iq_fu_free = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: fill one entry, then reset must clear it
        load_mode = 1;
        wr(0, 6'd1, 32'd5, 32'd7, 32'd12);
        load_mode = 0;
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        look(6'd1, 32'd5, 32'd7, 1'b0);
        chk("R1 dq_hit", 32'(dq_hit), 0);
        chk("R1 iq_res", iq_res, 0);

        // R2 R3 R5 R11: preload
        load_mode = 1;
        wr(0, 6'd1, 32'd5, 32'd7, 32'd12);
        wr(1, 6'd2, 32'd3, 32'd4, 32'd12);
        wr(2, 6'd1, 32'd5, 32'd7, 32'd99);
        wr(3, 6'd3, 32'd0, 32'd0, 32'hDEAD);
        wr(4, 6'h20, 32'd9, 32'd9, 32'd77);
        wr(DEPTH-1, 6'd6, 32'd1, 32'd2, 32'd3);
        // R6: lookups miss while loading
        look(6'd1, 32'd5, 32'd7, 1'b0);
        chk("R6 dq_hit", 32'(dq_hit), 0);
        chk("R6 iq_bypass", 32'(iq_bypass), 0);
        @(negedge clk); load_mode = 0;
        // R2 R10: write without load phase is dropped
        wr(5, 6'd4, 32'd1, 32'd1, 32'd55);

        // vector table walk: R4 R5 R3 R7 R8 R2
        for (int v = 0; v < NV; v++) begin
            logic [103:0] e;
            e = VEC[v];
            look(e[103:98], e[97:66], e[65:34], e[33]);
            chk("R4 dq_hit", 32'(dq_hit), 32'(e[32]));
            chk("R5 dq_res", dq_res, e[31:0]);
            chk("R7 dq_bypass", 32'(dq_bypass), 32'(e[32]));
            chk("R8 iq_hit", 32'(iq_hit), 32'(e[32]));
            chk("R4 iq_res", iq_res, e[31:0]);
            chk("R8 iq_bypass", 32'(iq_bypass), 32'(e[32] & ~e[33]));
        end

        // R4: valid low means miss
        @(negedge clk);
        dq_vld = 0; dq_opc = 6'd1; dq_a = 32'd5; dq_b = 32'd7;
        #1;
        chk("R4 dq_vld low", 32'(dq_hit), 0);

        // R11: independent queries, one at last index
        @(negedge clk);
        dq_vld = 1; dq_opc = 6'd6; dq_a = 32'd1; dq_b = 32'd2;
        iq_vld = 1; iq_opc = 6'd3; iq_a = 32'd0; iq_b = 32'd0; iq_fu_free = 0;
        #1;
        chk("R11 dq_res last idx", dq_res, 32'd3);
        chk("R11 iq_res", iq_res, 32'hDEAD);

        // R9: flush wins over simultaneous write
        @(negedge clk);
        load_mode = 1; flush = 1; ld_we = 1; ld_idx = IW'(6);
        ld_opc = 6'd7; ld_a = 32'd2; ld_b = 32'd2; ld_res = 32'd4;
        @(negedge clk);
        flush = 0; ld_we = 0; load_mode = 0;
        look(6'd1, 32'd5, 32'd7, 1'b0);
        chk("R9 flushed entry", 32'(dq_hit), 0);
        look(6'd7, 32'd2, 32'd2, 1'b0);
        chk("R9 write lost to flush", 32'(iq_hit), 0);
        // R2: reload after flush
        load_mode = 1;
        wr(0, 6'd1, 32'd5, 32'd7, 32'd12);
        @(negedge clk); load_mode = 0;
        look(6'd1, 32'd5, 32'd7, 1'b1);
        chk("R2 reload", dq_res, 32'd12);
        chk("R8 fu free no bypass", 32'(iq_bypass), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule